// File: doc/BRIEF.md
# Trigger Chain and Action Resolver

This block sits behind a bank of hardware triggers. Each trigger supplies a raw match bit for the current cycle, and it also supplies its chain bit, its action code and its debug-only ownership bit. The resolver groups the triggers into chains and decides which chains fire. A chain fires only when all of its members match in the same cycle, and only the action of its last member counts. The result is either a request for a breakpoint exception or a request for debug-mode entry, together with the index of the trigger that fired.

The block also holds the machine-mode trigger-enable control state. This is one live enable bit and one saved copy. While the enable is clear and the hart runs in machine mode, breakpoint-exception chains are suppressed. A trap into machine mode saves and clears the enable, and a machine-mode trap return restores it. Software can load both bits directly. The requests are combinational from the match inputs, so the pipeline sees them in the same cycle as the matches.

Top module: `trig_chain_resolver`

## Requirements
- R1: After reset, ctl_mte and ctl_mpte are 0. With no raw matches, brk_req and dbg_req are 0 and fire_idx is 0.
- R2: The action code is 4 bits per trigger and sits at action_flat[4*i+3:4*i]. Code 0 on a firing chain end raises brk_req. Code 1 raises dbg_req only if that trigger's dmode bit is 1. Code 1 with dmode 0, and codes 2 to 15, produce no request.
- R3: A chain fires only if every member matches in the same cycle. A chained member that does not match blocks the trigger with the next index.
- R4: Only the action and dmode of a chain's last member decide the request. The action and dmode values of the other members have no effect.
- R5: A chain begins at trigger 0, or at any trigger whose lower neighbour has chain 0. It ends at the first trigger with chain 0, and that trigger is part of the chain. A trigger with chain 1 at the top index never fires.
- R6: While priv_mach is 1 and ctl_mte is 0, chains whose last action is 0 raise no brk_req. Debug-entry chains are not affected, and neither are cycles with priv_mach 0.
- R7: If any debug-entry chain fires, dbg_req is 1 and brk_req is 0. fire_idx is the index of the last member of the lowest-indexed firing chain of the winning kind. fire_idx is 0 when nothing fires.
- R8: trap_enter at a clock edge copies ctl_mte into ctl_mpte and clears ctl_mte.
- R9: trap_ret without trap_enter at a clock edge copies ctl_mpte into ctl_mte and leaves ctl_mpte unchanged.
- R10: ctl_we without trap_enter or trap_ret at a clock edge loads ctl_mte from ctl_wdata[0] and ctl_mpte from ctl_wdata[1]. The order of precedence is trap_enter, then trap_ret, then ctl_we.
- R11: brk_req, dbg_req and fire_idx respond in the same cycle as the inputs, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| match_raw | input | NUM_TRIG | Raw per-trigger match this cycle |
| chain_bits | input | NUM_TRIG | Per-trigger chain bit |
| dmode_bits | input | NUM_TRIG | Per-trigger debug-only ownership bit |
| action_flat | input | NUM_TRIG*ACT_W | Packed per-trigger action codes |
| priv_mach | input | 1 | Hart is in machine mode |
| trap_enter | input | 1 | Trap into machine mode is taken |
| trap_ret | input | 1 | Machine-mode trap return |
| ctl_we | input | 1 | Load the enable control bits |
| ctl_wdata | input | 2 | Bit 0: new enable, bit 1: new saved enable |
| brk_req | output | 1 | Breakpoint-exception request |
| dbg_req | output | 1 | Debug-mode entry request |
| fire_idx | output | IDX_W | Index of the reported firing trigger |
| ctl_mte | output | 1 | Current machine-mode trigger enable |
| ctl_mpte | output | 1 | Saved trigger enable |

## Verification
The hardest case to reach is a long chain that becomes complete in exactly one cycle while a separate chain of the other action kind fires in the same cycle. Random stimulus almost never aligns every member's match. The bench therefore builds these cases on purpose: it places chains at index 0, in the middle, and open at the top index, and it drops single members from them. The random phase biases match density high and chain bits low, so partial and complete chains both appear often. Machine-mode suppression is reached by moving the enable through writes and trap entry and return, with priv_mach held high.

// File: rtl/trig_res_pkg.sv
package trig_res_pkg;
  // action codes the resolver acts on
  localparam int unsigned ACT_CODE_BRK = 0;
  localparam int unsigned ACT_CODE_DBG = 1;

  typedef struct packed {
    logic mpte;
    logic mte;
  } trig_en_t;
endpackage

// File: rtl/trig_chain_combine.sv
module trig_chain_combine #(
  parameter int unsigned NUM_TRIG = 8
) (
  input  logic [NUM_TRIG-1:0] match_raw,
  input  logic [NUM_TRIG-1:0] chain_bits,
  output logic [NUM_TRIG-1:0] grp_hit
);
  logic [NUM_TRIG-1:0] run_ok;

  // run_ok[i]: trigger i and all earlier members of its chain match
  always_comb begin
    run_ok = '0;
    for (int i = 0; i < int'(NUM_TRIG); i++) begin
      if (i == 0) begin
        run_ok[i] = match_raw[i];
      end else begin
        run_ok[i] = match_raw[i] & (~chain_bits[i-1] | run_ok[i-1]);
      end
    end
  end

  // a chain reports only at its closing member
  assign grp_hit = run_ok & ~chain_bits;
endmodule

// File: rtl/trig_action_decode.sv
module trig_action_decode
  import trig_res_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 8,
  parameter int unsigned ACT_W    = 4
) (
  input  logic [NUM_TRIG-1:0]       grp_hit,
  input  logic [NUM_TRIG*ACT_W-1:0] action_flat,
  input  logic [NUM_TRIG-1:0]       dmode_bits,
  input  logic                      suppress_brk,
  output logic [NUM_TRIG-1:0]       want_brk,
  output logic [NUM_TRIG-1:0]       want_dbg
);
  for (genvar gi = 0; gi < int'(NUM_TRIG); gi++) begin : g_dec
    logic [ACT_W-1:0] act_code;
    assign act_code     = action_flat[gi*ACT_W +: ACT_W];
    assign want_brk[gi] = grp_hit[gi] & (act_code == ACT_W'(ACT_CODE_BRK)) & ~suppress_brk;
    assign want_dbg[gi] = grp_hit[gi] & (act_code == ACT_W'(ACT_CODE_DBG)) & dmode_bits[gi];
  end
endmodule

// File: rtl/trig_low_pick.sv
module trig_low_pick #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req_vec,
  output logic             any_req,
  output logic [IDX_W-1:0] low_idx
);
  always_comb begin
    any_req = |req_vec;
    low_idx = '0;
    for (int i = int'(WIDTH) - 1; i >= 0; i--) begin
      if (req_vec[i]) low_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/trig_enable_ctl.sv
module trig_enable_ctl
  import trig_res_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trap_enter,
  input  logic       trap_ret,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output trig_en_t   en_q
);
  trig_en_t en_d;
  logic     en_ce;

  assign en_ce = trap_enter | trap_ret | wr_en;

  always_comb begin
    en_d = en_q;
    if (trap_enter) begin
      en_d.mpte = en_q.mte;
      en_d.mte  = 1'b0;
    end else if (trap_ret) begin
      en_d.mte  = en_q.mpte;
    end else if (wr_en) begin
      en_d.mte  = wr_data[0];
      en_d.mpte = wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/trig_chain_resolver.sv
module trig_chain_resolver
  import trig_res_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 8,
  parameter int unsigned ACT_W    = 4,
  localparam int unsigned IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_TRIG-1:0]       match_raw,
  input  logic [NUM_TRIG-1:0]       chain_bits,
  input  logic [NUM_TRIG-1:0]       dmode_bits,
  input  logic [NUM_TRIG*ACT_W-1:0] action_flat,
  input  logic                      priv_mach,
  input  logic                      trap_enter,
  input  logic                      trap_ret,
  input  logic                      ctl_we,
  input  logic [1:0]                ctl_wdata,
  output logic                      brk_req,
  output logic                      dbg_req,
  output logic [IDX_W-1:0]          fire_idx,
  output logic                      ctl_mte,
  output logic                      ctl_mpte
);
  trig_en_t            en_q;
  logic [NUM_TRIG-1:0] grp_hit;
  logic [NUM_TRIG-1:0] want_brk;
  logic [NUM_TRIG-1:0] want_dbg;
  logic                any_brk;
  logic                any_dbg;
  logic [IDX_W-1:0]    brk_idx;
  logic [IDX_W-1:0]    dbg_idx;
  logic                suppress_brk;

  trig_enable_ctl u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_enter (trap_enter),
    .trap_ret   (trap_ret),
    .wr_en      (ctl_we),
    .wr_data    (ctl_wdata),
    .en_q       (en_q)
  );

  assign suppress_brk = priv_mach & ~en_q.mte;

  trig_chain_combine #(.NUM_TRIG(NUM_TRIG)) u_comb (
    .match_raw  (match_raw),
    .chain_bits (chain_bits),
    .grp_hit    (grp_hit)
  );

  trig_action_decode #(.NUM_TRIG(NUM_TRIG), .ACT_W(ACT_W)) u_dec (
    .grp_hit      (grp_hit),
    .action_flat  (action_flat),
    .dmode_bits   (dmode_bits),
    .suppress_brk (suppress_brk),
    .want_brk     (want_brk),
    .want_dbg     (want_dbg)
  );

  trig_low_pick #(.WIDTH(NUM_TRIG)) u_pick_brk (
    .req_vec (want_brk),
    .any_req (any_brk),
    .low_idx (brk_idx)
  );

  trig_low_pick #(.WIDTH(NUM_TRIG)) u_pick_dbg (
    .req_vec (want_dbg),
    .any_req (any_dbg),
    .low_idx (dbg_idx)
  );

  // debug entry outranks the breakpoint exception
  always_comb begin
    dbg_req  = any_dbg;
    brk_req  = any_brk & ~any_dbg;
    fire_idx = '0;
    if (any_dbg)      fire_idx = dbg_idx;
    else if (any_brk) fire_idx = brk_idx;
  end

  assign ctl_mte  = en_q.mte;
  assign ctl_mpte = en_q.mpte;
endmodule

// File: rtl/trig_chain_resolver_chk.sv
module trig_chain_resolver_chk #(
  parameter int unsigned NUM_TRIG = 8,
  localparam int unsigned IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TRIG-1:0] match_raw,
  input logic                priv_mach,
  input logic                trap_enter,
  input logic                trap_ret,
  input logic                ctl_we,
  input logic [1:0]          ctl_wdata,
  input logic                brk_req,
  input logic                dbg_req,
  input logic [IDX_W-1:0]    fire_idx,
  input logic                ctl_mte,
  input logic                ctl_mpte
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_req && dbg_req)); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fire_idx) < int'(NUM_TRIG)); // R7
  AST_NO_MATCH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (match_raw == '0) |-> (!brk_req && !dbg_req)); // R3
  AST_MACH_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mach && !ctl_mte) |-> !brk_req); // R6
  AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> (!ctl_mte && (ctl_mpte == $past(ctl_mte)))); // R8
  AST_TRAP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !trap_enter) |=> ((ctl_mte == $past(ctl_mpte)) && $stable(ctl_mpte))); // R9
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !trap_enter && !trap_ret) |=> ({ctl_mpte, ctl_mte} == $past(ctl_wdata))); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !trap_enter && !trap_ret) |=> ($stable(ctl_mte) && $stable(ctl_mpte))); // R10
endmodule

bind trig_chain_resolver trig_chain_resolver_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .match_raw  (match_raw),
  .priv_mach  (priv_mach),
  .trap_enter (trap_enter),
  .trap_ret   (trap_ret),
  .ctl_we     (ctl_we),
  .ctl_wdata  (ctl_wdata),
  .brk_req    (brk_req),
  .dbg_req    (dbg_req),
  .fire_idx   (fire_idx),
  .ctl_mte    (ctl_mte),
  .ctl_mpte   (ctl_mpte)
);

// File: tb/test_trig_chain_resolver.sv
module test_trig_chain_resolver;
  localparam int N = 8;
  localparam int AW = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  match_raw, chain_bits, dmode_bits;
  logic [N*AW-1:0] action_flat;
  logic          priv_mach, trap_enter, trap_ret, ctl_we;
  logic [1:0]    ctl_wdata;
  logic          brk_req, dbg_req, ctl_mte, ctl_mpte;
  logic [IW-1:0] fire_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int mte_m, mpte_m;
  int e_brk, e_dbg, e_idx;

  always #5 clk = ~clk;

  trig_chain_resolver #(.NUM_TRIG(N), .ACT_W(AW)) i_trig_chain_resolver (
    .clk(clk), .rst_n(rst_n), .match_raw(match_raw), .chain_bits(chain_bits),
    .dmode_bits(dmode_bits), .action_flat(action_flat), .priv_mach(priv_mach),
    .trap_enter(trap_enter), .trap_ret(trap_ret), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .brk_req(brk_req), .dbg_req(dbg_req),
    .fire_idx(fire_idx), .ctl_mte(ctl_mte), .ctl_mpte(ctl_mpte)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: walk the triggers, tracking whether the open chain is intact
  task automatic model_outputs();
    int best_b, best_d;
    bit intact;
    best_b = -1; best_d = -1; intact = 1;
    for (int i = 0; i < N; i++) begin
      intact = intact && match_raw[i];
      if (!chain_bits[i]) begin
        if (intact) begin
          int a;
          a = int'(action_flat[i*AW +: AW]);
          if (a == 0 && !(priv_mach && mte_m == 0) && best_b < 0) best_b = i;
          if (a == 1 && dmode_bits[i] && best_d < 0) best_d = i;
        end
        intact = 1;
      end
    end
    e_dbg = (best_d >= 0);
    e_brk = (best_d < 0) && (best_b >= 0);
    e_idx = (best_d >= 0) ? best_d : ((best_b >= 0) ? best_b : 0);
  endtask

  task automatic set_act(input int idx, input int code);
    action_flat[idx*AW +: AW] = AW'(code);
  endtask

  task automatic clear_in();
    match_raw = '0; chain_bits = '0; dmode_bits = '0;
    action_flat = {(N*AW){1'b1}};
    priv_mach = 0; trap_enter = 0; trap_ret = 0; ctl_we = 0; ctl_wdata = 0;
  endtask

  // inputs already set (at negedge); check mid-cycle, then advance one edge
  task automatic step(input string tag, input bit hand, input int hb, input int hd, input int hi);
    #2;
    model_outputs();
    chk(brk_req === 1'(e_brk), {tag, " R2/R6 brk_req vs model"}, brk_req, e_brk);
    chk(dbg_req === 1'(e_dbg), {tag, " R2 dbg_req vs model"}, dbg_req, e_dbg);
    chk(int'(fire_idx) == e_idx, {tag, " R7 fire_idx vs model"}, fire_idx, e_idx);
    chk(int'(ctl_mte) == mte_m && int'(ctl_mpte) == mpte_m, {tag, " R10 enable state vs model"},
        {ctl_mpte, ctl_mte}, mpte_m * 2 + mte_m);
    if (hand) begin
      chk(brk_req === 1'(hb), {tag, " brk_req"}, brk_req, hb);
      chk(dbg_req === 1'(hd), {tag, " dbg_req"}, dbg_req, hd);
      chk(int'(fire_idx) == hi, {tag, " fire_idx"}, fire_idx, hi);
    end
    @(posedge clk);
    #1;
    if (trap_enter) begin mpte_m = mte_m; mte_m = 0; end
    else if (trap_ret) mte_m = mpte_m;
    else if (ctl_we) begin mte_m = ctl_wdata[0]; mpte_m = ctl_wdata[1]; end
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0; mte_m = 0; mpte_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_mte === 0 && ctl_mpte === 0, "R1 enable bits after reset", {ctl_mpte, ctl_mte}, 0);
    step("R1 idle", 1, 0, 0, 0);

    // R2 action decode, R11 same-cycle response
    match_raw[3] = 1; set_act(3, 0);
    step("R2 R11 brk at 3", 1, 1, 0, 3);
    match_raw[5] = 1; set_act(5, 1); dmode_bits[5] = 1;
    step("R2 dbg at 5", 1, 0, 1, 5);
    match_raw[5] = 1; set_act(5, 1); dmode_bits[5] = 0;
    step("R2 dbg needs dmode", 1, 0, 0, 0);
    match_raw[4] = 1; set_act(4, 2);
    step("R2 code 2 no request", 1, 0, 0, 0);
    match_raw[4] = 1; set_act(4, 15); dmode_bits[4] = 1;
    step("R2 code 15 no request", 1, 0, 0, 0);

    // R3/R4 chain 1-2-3, last member debug, earlier members brk code
    for (int k = 0; k < 4; k++) begin
      chain_bits[1] = 1; chain_bits[2] = 1;
      set_act(1, 0); set_act(2, 0); set_act(3, 1); dmode_bits[3] = 1;
      case (k)
        0: begin match_raw = 8'b0000_1110; step("R3 R4 full chain", 1, 0, 1, 3); end
        1: begin match_raw = 8'b0000_1010; step("R3 missing middle", 1, 0, 0, 0); end
        2: begin match_raw = 8'b0000_1000; step("R3 blocked last", 1, 0, 0, 0); end
        default: begin match_raw = 8'b0000_0110; step("R4 members alone", 1, 0, 0, 0); end
      endcase
    end

    // R5 chain start at 0, open chain at top
    chain_bits[0] = 1; set_act(1, 0); match_raw = 8'b0000_0011;
    step("R5 chain from 0", 1, 1, 0, 1);
    chain_bits[0] = 1; set_act(1, 0); match_raw = 8'b0000_0010;
    step("R5 chain from 0 partial", 1, 0, 0, 0);
    chain_bits[7] = 1; set_act(7, 0); match_raw[7] = 1;
    step("R5 open at top", 1, 0, 0, 0);

    // R7 priority
    match_raw = 8'b0100_0100; set_act(2, 0); set_act(6, 1); dmode_bits[6] = 1;
    step("R7 dbg over brk", 1, 0, 1, 6);
    match_raw = 8'b0001_0100; set_act(2, 0); set_act(4, 0);
    step("R7 lowest index", 1, 1, 0, 2);

    // R6 machine-mode suppression
    priv_mach = 1; match_raw[2] = 1; set_act(2, 0);
    step("R6 suppressed", 1, 0, 0, 0);
    priv_mach = 1; match_raw[6] = 1; set_act(6, 1); dmode_bits[6] = 1;
    step("R6 dbg unaffected", 1, 0, 1, 6);
    ctl_we = 1; ctl_wdata = 2'b01;
    step("R10 write mte", 0, 0, 0, 0);
    chk(ctl_mte === 1 && ctl_mpte === 0, "R10 write result", {ctl_mpte, ctl_mte}, 1);
    priv_mach = 1; match_raw[2] = 1; set_act(2, 0);
    step("R6 enabled", 1, 1, 0, 2);

    // R8/R9 trap save and restore
    trap_enter = 1;
    step("R8 trap enter", 0, 0, 0, 0);
    chk(ctl_mte === 0 && ctl_mpte === 1, "R8 saved", {ctl_mpte, ctl_mte}, 2);
    trap_ret = 1;
    step("R9 trap ret", 0, 0, 0, 0);
    chk(ctl_mte === 1 && ctl_mpte === 1, "R9 restored", {ctl_mpte, ctl_mte}, 3);
    trap_enter = 1; trap_ret = 1; ctl_we = 1; ctl_wdata = 2'b01;
    step("R10 precedence", 0, 0, 0, 0);
    chk(ctl_mte === 0 && ctl_mpte === 1, "R10 enter wins", {ctl_mpte, ctl_mte}, 2);
    trap_ret = 1; ctl_we = 1; ctl_wdata = 2'b00;
    step("R10 ret over write", 0, 0, 0, 0);
    chk(ctl_mte === 1 && ctl_mpte === 1, "R10 ret wins", {ctl_mpte, ctl_mte}, 3);

    // random phase against the reference model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        int r;
        r = int'($urandom_range(0, 9));
        match_raw[i]  = (r < 7);
        chain_bits[i] = ($urandom_range(0, 9) < 3);
        dmode_bits[i] = $urandom_range(0, 1);
        r = int'($urandom_range(0, 5));
        set_act(i, (r < 3) ? 0 : ((r < 5) ? 1 : int'($urandom_range(2, 15))));
      end
      priv_mach  = $urandom_range(0, 1);
      trap_enter = ($urandom_range(0, 15) == 0);
      trap_ret   = ($urandom_range(0, 15) == 0);
      ctl_we     = ($urandom_range(0, 7) == 0);
      ctl_wdata  = 2'($urandom_range(0, 3));
      step("R3 R5 random", 0, 0, 0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule